// File: doc/BRIEF.md
# UART Register Front End

This block is the part of a UART that the CPU sees. It sits between a small register port (two addresses: a data location and a status location) and the separate transmit and receive shift engines. A write to the data location fills a one-entry transmit holding buffer. That buffer hands its character to the transmit shifter as soon as the transmitter is enabled and the shifter reports that it is empty. A read of the same location returns the oldest character from a two-entry receive queue. Each queue entry holds the character together with its own frame, parity and overflow bits.

The status location reports the state of the receive queue, the transmit holding buffer and the transmit-complete event. The error bits always describe the oldest unread character. Software must therefore read status before it reads the data that pops that character. Characters can be 5, 6, 7, 8 or 9 bits wide. Unused upper bits are dropped on transmit and read back as zero on receive. The ninth transmit bit is written through status bit 0, and the ninth received bit is read back in that same bit.

Top module: `uart_regif`

## Requirements
- R1: After reset the status location reads 0x20 (only data-register-empty set), and `tx_load` is low.
- R2: A data write made while data-register-empty (status bit 5) is clear is discarded: the buffered character later delivered to the shifter is the earlier one.
- R3: While the buffer is full, `tx_en` is high and `tx_shift_empty` is high, `tx_load` pulses for one cycle with the buffered character on `tx_data`, and data-register-empty is set again in the next cycle.
- R4: The `char_size` encoding is 0=5 bits, 1=6, 2=7, 3=8, 4..7=9 bits. Transmit bits at or above the character width read as zero on `tx_data`. In 9-bit mode, `tx_data[8]` is the value last written to status bit 0.
- R5: On a read of the data location, bits at or above the character width read as zero. In 9-bit mode, status bit 0 shows bit 8 of the oldest character; in any other mode it reads zero.
- R6: The receive queue holds two characters and returns them in arrival order. Status bits 4 (frame error) and 2 (parity error) belong to the oldest unread character.
- R7: Status bit 7 (receive complete) is high exactly while the queue holds unread data. Clearing `rx_en` empties the queue, and characters that arrive while `rx_en` is low are ignored.
- R8: A character that arrives while both entries are full is dropped. Status bit 3 (buffer overflow) is then set on the newest stored entry, and it shows when that entry becomes the oldest.
- R9: Status bit 6 (transmit complete) sets when `tx_frame_done` pulses while the holding buffer is empty. It clears on `txc_ack` or on a status write with bit 6 set.
- R10: A status write with bit 7 set discards the oldest unread character.
- R11: Status bit 1 always reads zero. Writes to status bits 5..1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of the data location pops the queue) |
| bus_addr | input | 1 | 0 = data location, 1 = status location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location (combinational) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the queue |
| char_size | input | 3 | Character width code |
| tx_load | output | 1 | Strobe moving the buffered character into the shifter |
| tx_data | output | 9 | Character presented with `tx_load` |
| tx_shift_empty | input | 1 | Transmit shifter is idle |
| tx_frame_done | input | 1 | One-cycle pulse when a frame has fully left the shifter |
| txc_ack | input | 1 | Transmit-complete vector acknowledge |
| rx_valid | input | 1 | One-cycle pulse when a received character is ready |
| rx_data | input | 9 | Received character |
| rx_ferr | input | 1 | Frame error of the received character |
| rx_perr | input | 1 | Parity error of the received character |

## Verification
On every cycle the assertions check the following: the queue never exceeds two entries, a flush leaves it empty, a drop on a full queue keeps the count, a write while the buffer is full leaves the buffer unchanged, a load always frees the buffer, and an acknowledge clears transmit complete. Only the bench scenarios can show the rest. These are the masking of every character width on both paths, the order in which queued characters return, the pairing of error and overflow bits with the right character, the ninth-bit paths, and the visible effect of ignored writes. The bench sweeps all five widths against several bit patterns and computes each expected word arithmetically.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int CHAR_W = 9;

  // status bit positions (software decodes these)
  localparam int ST_RXC  = 7;
  localparam int ST_TXC  = 6;
  localparam int ST_DRE  = 5;
  localparam int ST_FERR = 4;
  localparam int ST_OVF  = 3;
  localparam int ST_PERR = 2;
  localparam int ST_RSVD = 1;
  localparam int ST_BIT9 = 0;

  typedef enum logic {
    ADDR_DATA = 1'b0,
    ADDR_STAT = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              ferr;
    logic              perr;
    logic              ovf;
  } rx_entry_t;

  // width code -> mask of live character bits
  function automatic logic [CHAR_W-1:0] char_mask(input logic [2:0] code);
    logic [CHAR_W-1:0] m;
    case (code)
      3'd0:    m = 9'h01F;
      3'd1:    m = 9'h03F;
      3'd2:    m = 9'h07F;
      3'd3:    m = 9'h0FF;
      default: m = 9'h1FF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_req,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              tx_en,
  input  logic              shift_empty,
  output logic              full,
  output logic              load,
  output logic [CHAR_W-1:0] hold_char
);

  logic              full_d;
  logic              hold_en;
  logic [CHAR_W-1:0] hold_d;

  always_comb begin
    load    = full & tx_en & shift_empty;
    hold_en = wr_req & ~full;
    hold_d  = wr_char;
    full_d  = full;
    if (load)    full_d = 1'b0;
    if (hold_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full      <= 1'b0;
      hold_char <= '0;
    end else begin
      full <= full_d;
      if (hold_en) hold_char <= hold_d;
    end
  end

  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && full && !load) |=> (full && $stable(hold_char)));

  a_r3_load_frees_buffer: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> !full);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_regif_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      not_empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rd_ptr_d, wr_ptr_d, newest;
  logic [CW-1:0] count, count_d;
  logic          do_pop, do_push, do_drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    do_pop  = pop & (count != '0);
    do_push = push & ((count != FULL_CNT) | do_pop);
    do_drop = push & (count == FULL_CNT) & ~do_pop;
    newest  = (wr_ptr == '0) ? LAST_IDX : wr_ptr - PW'(1);
    rd_ptr_d = do_pop  ? bump(rd_ptr) : rd_ptr;
    wr_ptr_d = do_push ? bump(wr_ptr) : wr_ptr;
    count_d  = count;
    if (do_push && !do_pop) count_d = count + CW'(1);
    if (do_pop && !do_push) count_d = count - CW'(1);
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      count_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      count  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we, slot_tag;
    always_comb begin
      slot_we  = do_push & ~flush & (wr_ptr == PW'(i));
      slot_tag = do_drop & ~flush & (newest == PW'(i));
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[i] <= '0;
      end else if (slot_we) begin
        mem[i] <= push_entry;
      end else if (slot_tag) begin
        mem[i].ovf <= 1'b1;
      end
    end
  end

  always_comb begin
    head      = mem[rd_ptr];
    not_empty = (count != '0);
  end

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_ni)
    count <= FULL_CNT);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |=> (count == '0));

  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && !pop && !flush && count == FULL_CNT) |=> (count == FULL_CNT));

endmodule

// File: rtl/uart_txc_flag.sv
module uart_txc_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic frame_done,
  input  logic buf_full,
  input  logic ack,
  input  logic sw_clear,
  output logic txc
);

  logic txc_d, set_ev;

  always_comb begin
    set_ev = frame_done & ~buf_full;
    txc_d  = txc;
    if (ack || sw_clear) txc_d = 1'b0;
    if (set_ev)          txc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) txc <= 1'b0;
    else         txc <= txc_d;
  end

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack && !frame_done) |=> !txc);

  a_r9_busy_no_set: assert property (@(posedge clk) disable iff (!rst_ni)
    (!txc && frame_done && buf_full) |=> !txc);

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [2:0]        char_size,
  output logic              tx_load,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_shift_empty,
  input  logic              tx_frame_done,
  input  logic              txc_ack,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              rx_perr
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic              wr_data, wr_stat, rd_data;
  logic              tx_full;
  logic [CHAR_W-1:0] live_mask, tx_char;
  logic              bit9_q, bit9_d, bit9_en;
  logic              q_pop, q_push, q_nonempty;
  rx_entry_t         q_in, q_head;
  logic              txc;
  logic [7:0]        stat_word, data_word;
  logic [CHAR_W-1:0] head_masked;
  logic              nine_bit;

  always_comb begin
    wr_data   = bus_wr & (bus_addr == ADDR_DATA);
    wr_stat   = bus_wr & (bus_addr == ADDR_STAT);
    rd_data   = bus_rd & (bus_addr == ADDR_DATA);
    live_mask = char_mask(char_size);
    nine_bit  = live_mask[CHAR_W-1];
    tx_char   = {bit9_q, bus_wdata} & live_mask;
    bit9_en   = wr_stat;
    bit9_d    = bus_wdata[ST_BIT9];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      bit9_q <= 1'b0;
    else if (bit9_en) bit9_q <= bit9_d;
  end

  uart_tx_hold u_tx_hold (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .wr_req      (wr_data),
    .wr_char     (tx_char),
    .tx_en       (tx_en),
    .shift_empty (tx_shift_empty),
    .full        (tx_full),
    .load        (tx_load),
    .hold_char   (tx_data)
  );

  always_comb begin
    q_push     = rx_valid & rx_en;
    q_pop      = rd_data | (wr_stat & bus_wdata[ST_RXC]);
    q_in.data  = rx_data;
    q_in.ferr  = rx_ferr;
    q_in.perr  = rx_perr;
    q_in.ovf   = 1'b0;
  end

  uart_rx_queue #(.DEPTH(RX_DEPTH)) u_rx_queue (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .flush      (~rx_en),
    .push       (q_push),
    .push_entry (q_in),
    .pop        (q_pop),
    .head       (q_head),
    .not_empty  (q_nonempty)
  );

  uart_txc_flag u_txc (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .frame_done (tx_frame_done),
    .buf_full   (tx_full),
    .ack        (txc_ack),
    .sw_clear   (wr_stat & bus_wdata[ST_TXC]),
    .txc        (txc)
  );

  always_comb begin
    head_masked        = q_nonempty ? (q_head.data & live_mask) : '0;
    stat_word          = '0;
    stat_word[ST_RXC]  = q_nonempty;
    stat_word[ST_TXC]  = txc;
    stat_word[ST_DRE]  = ~tx_full;
    stat_word[ST_FERR] = q_nonempty & q_head.ferr;
    stat_word[ST_OVF]  = q_nonempty & q_head.ovf;
    stat_word[ST_PERR] = q_nonempty & q_head.perr;
    stat_word[ST_RSVD] = 1'b0;
    stat_word[ST_BIT9] = nine_bit & head_masked[CHAR_W-1];
    data_word          = head_masked[7:0];
    bus_rdata          = (bus_addr == ADDR_STAT) ? stat_word : data_word;
  end

  a_r7_rxc_tracks_queue: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rx_en) |=> !stat_word[ST_RXC]);

  a_r3_load_needs_enable: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_full && !tx_en) |=> tx_full);

endmodule

// File: tb/uart_regif_tb.sv
module uart_regif_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tx_en, rx_en;
  logic [2:0] char_size;
  logic       tx_load;
  logic [8:0] tx_data;
  logic       tx_shift_empty, tx_frame_done, txc_ack;
  logic       rx_valid;
  logic [8:0] rx_data;
  logic       rx_ferr, rx_perr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_en(tx_en), .rx_en(rx_en),
    .char_size(char_size), .tx_load(tx_load), .tx_data(tx_data),
    .tx_shift_empty(tx_shift_empty), .tx_frame_done(tx_frame_done), .txc_ack(txc_ack),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_put(input logic [8:0] d, input logic fe, input logic pe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_ferr = fe; rx_perr = pe;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain(input string tag, input logic [8:0] exp);
    @(negedge clk);
    tx_shift_empty = 1'b1;
    #1;
    check({tag, " load"}, 16'(tx_load), 16'd1);
    check({tag, " data"}, 16'(tx_data), 16'(exp));
    @(negedge clk);
    tx_shift_empty = 1'b0;
    #1;
    check({tag, " load drops"}, 16'(tx_load), 16'd0);
  endtask

  function automatic logic [8:0] mask_of(input int sz);
    int w;
    w = (sz >= 4) ? 9 : 5 + sz;
    return 9'((1 << w) - 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [8:0] pats [5];
    pats[0] = 9'h1FF; pats[1] = 9'h0AA; pats[2] = 9'h155; pats[3] = 9'h000; pats[4] = 9'h13C;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_en = 1; rx_en = 1; char_size = 3'd3; tx_shift_empty = 0; tx_frame_done = 0;
    txc_ack = 0; rx_valid = 0; rx_data = 0; rx_ferr = 0; rx_perr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    rd(1'b1, r);  check("R1 status", 16'(r), 16'h20);
    check("R1 tx_load", 16'(tx_load), 16'd0);

    // R4 + R3: every width, several patterns
    for (int sz = 0; sz < 5; sz++) begin
      char_size = 3'(sz);
      for (int k = 0; k < 5; k++) begin
        logic [8:0] e;
        wr(1'b1, {7'd0, pats[k][8]});
        wr(1'b0, pats[k][7:0]);
        rd(1'b1, r); check("R3 dre low when full", 16'(r[5]), 16'd0);
        e = pats[k] & mask_of(sz);
        drain("R4 tx mask", e);
        rd(1'b1, r); check("R3 dre back", 16'(r[5]), 16'd1);
      end
    end

    // R2: write while full is dropped
    char_size = 3'd3;
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'hC3);
    drain("R2 first kept", 9'h05A);

    // R5 + R6: receive widths, error bits with head
    for (int sz = 0; sz < 5; sz++) begin
      char_size = 3'(sz);
      for (int k = 0; k < 5; k++) begin
        logic fe, pe;
        logic [8:0] e;
        fe = k[0]; pe = k[1];
        e = pats[k] & mask_of(sz);
        rx_put(pats[k], fe, pe);
        rd(1'b1, r);
        check("R6 status", 16'(r),
              16'({1'b1, 1'b0, 1'b1, fe, 1'b0, pe, 1'b0, (sz >= 4) ? pats[k][8] : 1'b0}));
        rd(1'b0, r); check("R5 rx mask", 16'(r), 16'(e[7:0]));
        rd(1'b1, r); check("R7 rxc clears", 16'(r), 16'h20);
      end
    end

    // R6 + R8: order and overflow
    char_size = 3'd3;
    rx_put(9'h011, 1'b1, 1'b0);
    rx_put(9'h022, 1'b0, 1'b1);
    rx_put(9'h033, 1'b0, 1'b0);
    rd(1'b1, r); check("R8 head no ovf", 16'(r), 16'hB0);
    rd(1'b0, r); check("R6 first out", 16'(r), 16'h11);
    rd(1'b1, r); check("R8 ovf on newest", 16'(r), 16'hAC);
    rd(1'b0, r); check("R6 second out", 16'(r), 16'h22);
    rd(1'b1, r); check("R8 third dropped", 16'(r), 16'h20);

    // R7: flush and ignore while disabled
    rx_put(9'h044, 1'b0, 1'b0);
    rx_put(9'h055, 1'b0, 1'b0);
    @(negedge clk); rx_en = 1'b0;
    rx_put(9'h066, 1'b0, 1'b0);
    rd(1'b1, r); check("R7 flushed", 16'(r), 16'h20);
    rx_en = 1'b1;
    rd(1'b1, r); check("R7 ignored while off", 16'(r), 16'h20);

    // R10: write-one to bit 7 discards head
    rx_put(9'h077, 1'b0, 1'b0);
    rx_put(9'h088, 1'b0, 1'b0);
    wr(1'b1, 8'h80);
    rd(1'b0, r); check("R10 head discarded", 16'(r), 16'h88);
    rd(1'b1, r); check("R10 empty", 16'(r), 16'h20);

    // R9: transmit complete
    @(negedge clk); tx_frame_done = 1'b1;
    @(negedge clk); tx_frame_done = 1'b0;
    rd(1'b1, r); check("R9 txc set", 16'(r), 16'h60);
    wr(1'b1, 8'h40);
    rd(1'b1, r); check("R9 sw clear", 16'(r), 16'h20);
    @(negedge clk); tx_frame_done = 1'b1;
    @(negedge clk); tx_frame_done = 1'b0; txc_ack = 1'b1;
    @(negedge clk); txc_ack = 1'b0;
    rd(1'b1, r); check("R9 ack clear", 16'(r), 16'h20);
    wr(1'b0, 8'h12);
    @(negedge clk); tx_frame_done = 1'b1;
    @(negedge clk); tx_frame_done = 1'b0;
    rd(1'b1, r); check("R9 no set while full", 16'(r), 16'h00);
    drain("R9 drain", 9'h012);

    // R11: reserved and read-only bits
    wr(1'b1, 8'h3E);
    rd(1'b1, r); check("R11 ro bits", 16'(r), 16'h20);
    check("R11 reserved zero", 16'(r[1]), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule